// File: doc/BRIEF.md
# Tile INT8 Multiply-Accumulate Engine

This engine multiplies two tiles of signed 8-bit data and adds the product into a third tile of signed 32-bit accumulators, C += A x B. A single start pulse launches the whole computation. The engine then runs on its own for many cycles, reading tile rows through a simple row-read port and writing the updated C rows through a row-write port. The tile storage lives outside the block.

The shapes of the three tiles come in as inputs: a row count and a bytes-per-row count for each tile. They are captured when the start is accepted and checked before any arithmetic is done. A shape set that cannot form a valid product ends the command at once with an error flag, and C is left alone. Matrices larger than one tile are built up by issuing the command repeatedly, since every run adds into whatever C already holds.

The engine handles one C row at a time. For each row it reads the C row, then the matching A row, then every B row it needs. It adds the dot products into the row and writes the row back before it moves to the next one.

Top module: `tile_mma`

## Requirements
- R1: A start whose captured shapes break any rule ends in an error. The rules are: every row count in 1..MAX_ROWS; every bytes-per-row count in 4..MAX_COLSB and a multiple of 4; C rows equal A rows; C bytes-per-row equals B bytes-per-row; A bytes-per-row divided by 4 equals B rows. On an error, busy is high for exactly one cycle, then `done` and `err` pulse together, and no C row is written.
- R2: On a valid command, C lane n of row m (bits [32n+31:32n] of the row) grows by the sum over k < A bytes-per-row of A[m] byte k times B[k/4] byte 4n+(k mod 4). Byte j of a row is bits [8j+7:8j], and all bytes are signed.
- R3: Accumulation wraps modulo 2^32 and never saturates.
- R4: busy rises the cycle after an accepted start and stays high for 1 + M*(K+4) cycles, where M is the row count of A and K is the row count of B. `done` then pulses for one cycle, with busy low in that cycle.
- R5: A start that arrives while busy is high is ignored, and so are any shape inputs that change during that time.
- R6: Each of the first M C rows is written exactly once, in ascending row order. C rows at index M or above are never written.
- R7: Lanes n at or above C bytes-per-row divided by 4 keep their old values in every written row.
- R8: Reads are requested with `rd_en`, a tile select (0 = A, 1 = B, 2 = C) and a row index. The row data is expected on `rd_data` in the following cycle.
- R9: After reset, busy, done, err, rd_en and wr_en are all low.
- R10: Running the same command twice adds the product into C twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command pulse |
| a_rows | input | RW | Row count of A |
| a_colsb | input | CW | Bytes per row of A |
| b_rows | input | RW | Row count of B |
| b_colsb | input | CW | Bytes per row of B |
| c_rows | input | RW | Row count of C |
| c_colsb | input | CW | Bytes per row of C |
| rd_en | output | 1 | Row read request |
| rd_sel | output | 2 | Tile select for the read |
| rd_row | output | IW | Row index for the read |
| rd_data | input | DW | Row data, one cycle after the request |
| wr_en | output | 1 | C row write strobe |
| wr_row | output | IW | C row index to write |
| wr_data | output | DW | Updated C row |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Shape error, valid with done |

## Verification
The two cases that are hardest to reach from the ports are a 32-bit wrap inside a single lane and a second start that lands in the middle of a run. The bench forces the wrap by preloading C lanes just below the signed limit and filling A and B with the byte value -128, so that every product is large and positive. It pokes a start with invalid shapes a few cycles into a valid run and expects a bit-exact result and an unchanged busy length. Beyond those two cases, the bench sweeps every legal shape of a reduced 4-row, 16-byte configuration with random data, and runs one case for each shape rule that can be broken.

// File: rtl/tile_mma.sv
module tile_mma #(
  parameter int MAX_ROWS  = 16,
  parameter int MAX_COLSB = 64,
  localparam int LANES = MAX_COLSB / 4,
  localparam int RW    = $clog2(MAX_ROWS + 1),
  localparam int CW    = $clog2(MAX_COLSB + 1),
  localparam int IW    = $clog2(MAX_ROWS),
  localparam int DW    = MAX_COLSB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] a_rows,
  input  logic [CW-1:0] a_colsb,
  input  logic [RW-1:0] b_rows,
  input  logic [CW-1:0] b_colsb,
  input  logic [RW-1:0] c_rows,
  input  logic [CW-1:0] c_colsb,
  output logic          rd_en,
  output logic [1:0]    rd_sel,
  output logic [IW-1:0] rd_row,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_row,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RC, S_RA, S_RB, S_WAIT, S_WR} st_t;

  localparam logic [1:0] TILE_A = 2'd0;
  localparam logic [1:0] TILE_B = 2'd1;
  localparam logic [1:0] TILE_C = 2'd2;

  localparam logic [1:0] PD_NONE = 2'd0;
  localparam logic [1:0] PD_C    = 2'd1;
  localparam logic [1:0] PD_A    = 2'd2;
  localparam logic [1:0] PD_B    = 2'd3;

  st_t st;
  logic [RW-1:0] ar_q, br_q, cr_q;
  logic [CW-1:0] acb_q, bcb_q, ccb_q;
  logic [RW-1:0] row, kk;
  logic [1:0]    pend;
  logic [IW-1:0] pk;
  logic [DW-1:0] arow;
  logic [31:0]   acc [LANES];
  logic [31:0]   dot [LANES];
  logic [CW-1:0] nlanes;
  logic          rows_ok, cols_ok, shape_ok;

  // shape rules on the captured configuration
  assign rows_ok = ar_q != '0 && ar_q <= RW'(MAX_ROWS) && cr_q == ar_q &&
                   br_q != '0 && br_q <= RW'(MAX_ROWS);
  assign cols_ok = acb_q >= CW'(4) && acb_q <= CW'(MAX_COLSB) && acb_q[1:0] == 2'b00 &&
                   bcb_q >= CW'(4) && bcb_q <= CW'(MAX_COLSB) && bcb_q[1:0] == 2'b00 &&
                   ccb_q == bcb_q && (acb_q >> 2) == CW'(br_q);
  assign shape_ok = rows_ok && cols_ok;
  assign nlanes   = ccb_q >> 2;

  assign busy   = st != S_IDLE;
  assign rd_en  = st == S_RC || st == S_RA || st == S_RB;
  assign rd_sel = st == S_RC ? TILE_C : (st == S_RA ? TILE_A : TILE_B);
  assign rd_row = st == S_RB ? kk[IW-1:0] : row[IW-1:0];
  assign wr_en  = st == S_WR;
  assign wr_row = row[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ar_q  <= '0;
      br_q  <= '0;
      cr_q  <= '0;
      acb_q <= '0;
      bcb_q <= '0;
      ccb_q <= '0;
      row   <= '0;
      kk    <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          ar_q  <= a_rows;
          br_q  <= b_rows;
          cr_q  <= c_rows;
          acb_q <= a_colsb;
          bcb_q <= b_colsb;
          ccb_q <= c_colsb;
          st    <= S_CHK;
        end
        S_CHK: begin
          row <= '0;
          if (shape_ok) st <= S_RC;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        S_RC: st <= S_RA;
        S_RA: begin
          kk <= '0;
          st <= S_RB;
        end
        S_RB: begin
          kk <= kk + 1'b1;
          if (kk + 1'b1 == br_q) st <= S_WAIT;
        end
        S_WAIT: st <= S_WR;
        S_WR: begin
          if (row + 1'b1 == ar_q) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            row <= row + 1'b1;
            st  <= S_RC;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // tag of the read whose data arrives next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= PD_NONE;
      pk   <= '0;
    end else begin
      pend <= !rd_en ? PD_NONE : (st == S_RC ? PD_C : (st == S_RA ? PD_A : PD_B));
      pk   <= kk[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (pend == PD_A) arow <= rd_data;
  end

  always_comb begin : dotp
    logic signed [7:0]  av, bv;
    logic signed [15:0] p;
    logic [31:0]        s;
    for (int n = 0; n < LANES; n++) begin
      s = '0;
      for (int j = 0; j < 4; j++) begin
        av = arow[32*pk + 8*j +: 8];
        bv = rd_data[32*n + 8*j +: 8];
        p  = av * bv;
        s  = s + 32'(p);
      end
      dot[n] = s;
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    always_ff @(posedge clk) begin
      if (pend == PD_C) acc[n] <= rd_data[32*n +: 32];
      else if (pend == PD_B && CW'(n) < nlanes) acc[n] <= acc[n] + dot[n];
    end
    assign wr_data[32*n +: 32] = acc[n];
  end

  p_err_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_err_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && !shape_ok) |=> !wr_en && !busy);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ar_q) && $stable(br_q) && $stable(ccb_q));
  p_wr_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy && RW'(wr_row) < ar_q);
  p_rd_sel_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy && rd_sel != 2'd3 && !wr_en);

endmodule

// File: tb/tile_mma_bench.sv
module tile_mma_bench;
  localparam int MR = 4;
  localparam int MC = 16;
  localparam int RW = $clog2(MR + 1);
  localparam int CW = $clog2(MC + 1);
  localparam int IW = $clog2(MR);
  localparam int DW = MC * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] a_rows = '0, b_rows = '0, c_rows = '0;
  logic [CW-1:0] a_colsb = '0, b_colsb = '0, c_colsb = '0;
  logic rd_en, wr_en, busy, done, err;
  logic [1:0] rd_sel;
  logic [IW-1:0] rd_row, wr_row;
  logic [DW-1:0] rd_data, wr_data;

  tile_mma #(.MAX_ROWS(MR), .MAX_COLSB(MC)) u_tile_mma (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_rows(a_rows), .a_colsb(a_colsb), .b_rows(b_rows), .b_colsb(b_colsb),
    .c_rows(c_rows), .c_colsb(c_colsb),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_row(rd_row), .rd_data(rd_data),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err));

  always #2 clk = ~clk;

  logic [DW-1:0] ma [MR];
  logic [DW-1:0] mb [MR];
  logic [DW-1:0] mc [MR];
  logic [DW-1:0] mc_pre [MR];
  logic [DW-1:0] c0 [MR];
  logic load = 1'b0;
  logic [IW-1:0] wlog [1024];
  int wcnt = 0;
  int bcnt = 0;
  int tests = 0;
  int fails = 0;

  always @(posedge clk) begin
    if (load) mc <= mc_pre;
    else if (wr_en) begin
      mc[wr_row] <= wr_data;
      wlog[wcnt % 1024] <= wr_row;
      wcnt <= wcnt + 1;
    end
    if (rd_en) rd_data <= rd_sel == 2'd0 ? ma[rd_row] : (rd_sel == 2'd1 ? mb[rd_row] : mc[rd_row]);
    if (busy) bcnt <= bcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  task automatic load_c(input bit rnd, input logic [31:0] fillv);
    for (int m = 0; m < MR; m++)
      for (int n = 0; n < MC/4; n++)
        mc_pre[m][32*n +: 32] = rnd ? $urandom : fillv;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
  endtask

  task automatic fill_ab(input bit rnd, input logic [7:0] v);
    for (int m = 0; m < MR; m++)
      for (int j = 0; j < MC; j++) begin
        ma[m][8*j +: 8] = rnd ? 8'($urandom) : v;
        mb[m][8*j +: 8] = rnd ? 8'($urandom) : v;
      end
  endtask

  task automatic run_op(input int ar, input int acb, input int br, input int bcb,
                        input int cr, input int ccb, input int poke, input string tag);
    bit bad, got, gerr;
    int cnt, b0, w0, wn;
    logic signed [7:0] x, y;
    int e;
    bad = !(ar >= 1 && ar <= MR && cr == ar && br >= 1 && br <= MR &&
            acb >= 4 && acb <= MC && acb % 4 == 0 &&
            bcb >= 4 && bcb <= MC && bcb % 4 == 0 && ccb == bcb && acb / 4 == br);
    @(negedge clk);
    c0 = mc;
    b0 = bcnt;
    w0 = wcnt;
    a_rows = RW'(ar); a_colsb = CW'(acb); b_rows = RW'(br);
    b_colsb = CW'(bcb); c_rows = RW'(cr); c_colsb = CW'(ccb);
    start = 1'b1;
    cnt = 0; got = 0; gerr = 0;
    while (!got && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      if (poke != 0 && cnt == poke) begin
        start = 1'b1;
        a_rows = RW'(7); b_rows = RW'(1); c_colsb = CW'(3);
      end else start = 1'b0;
      if (done) begin
        got = 1;
        gerr = err;
      end
    end
    chk(got, {tag, " R4 done seen"}, got, 1);
    @(negedge clk);
    chk(!done, {tag, " R4 done one cycle"}, done, 0);
    chk(gerr == bad, {tag, bad ? " R1 err flag" : " R1 err clear"}, gerr, bad);
    chk(bcnt - b0 == (bad ? 1 : 1 + ar * (br + 4)), {tag, bad ? " R1 busy length" : " R4 busy length"},
        bcnt - b0, bad ? 1 : 1 + ar * (br + 4));
    wn = wcnt - w0;
    chk(wn == (bad ? 0 : ar), {tag, " R6 write count"}, wn, bad ? 0 : ar);
    if (!bad)
      for (int i = 0; i < wn && i < ar; i++)
        chk(int'(wlog[(w0 + i) % 1024]) == i, {tag, " R6 write order"}, wlog[(w0 + i) % 1024], i);
    for (int m = 0; m < MR; m++)
      for (int n = 0; n < MC/4; n++) begin
        e = int'(c0[m][32*n +: 32]);
        if (!bad && m < ar && n < ccb / 4)
          for (int k = 0; k < acb; k++) begin
            x = ma[m][8*k +: 8];
            y = mb[k/4][8*(4*n + k%4) +: 8];
            e = e + int'(x) * int'(y);
          end
        chk(mc[m][32*n +: 32] == 32'(e),
            {tag, bad ? " R1 C unchanged" : (m >= ar ? " R6 row untouched" :
                  (n >= ccb / 4 ? " R7 lane kept" : " R2 R8 element"))},
            mc[m][32*n +: 32], 32'(e));
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_en && !wr_en, "R9 reset outputs",
        {busy, done, err, rd_en, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R9 idle after reset", {busy, done, rd_en, wr_en}, 0);

    for (int m = 1; m <= MR; m++)
      for (int k = 1; k <= MC/4; k++)
        for (int n = 1; n <= MC/4; n++) begin
          fill_ab(1, 8'h00);
          if ((m + k + n) % 2 == 0) load_c(1, 32'h0);
          run_op(m, 4*k, k, 4*n, m, 4*n, 0, "sweep");
        end

    fill_ab(1, 8'h00);
    load_c(1, 32'h0);
    run_op(MR, MC, MC/4, MC, MR, MC, 0, "R10 first");
    run_op(MR, MC, MC/4, MC, MR, MC, 0, "R10 second");

    fill_ab(0, 8'h80);
    load_c(0, 32'h7FFF_F000);
    run_op(MR, MC, MC/4, MC, MR, MC, 0, "R3 wrap");
    run_op(2, 8, 2, 12, 2, 12, 0, "R3 wrap again");

    fill_ab(1, 8'h00);
    run_op(3, 8, 2, 12, 3, 12, 5, "R5 poke early");
    run_op(2, 16, 4, 8, 2, 8, 17, "R5 poke late");

    run_op(0, 8, 2, 8, 0, 8, 0, "R1 zero rows");
    run_op(5, 8, 2, 8, 5, 8, 0, "R1 rows over max");
    run_op(2, 6, 2, 8, 2, 8, 0, "R1 colsb not x4");
    run_op(2, 20, 5, 8, 2, 8, 0, "R1 colsb over max");
    run_op(2, 8, 2, 8, 3, 8, 0, "R1 c rows mismatch");
    run_op(2, 8, 2, 8, 2, 12, 0, "R1 c colsb mismatch");
    run_op(2, 8, 3, 8, 2, 8, 0, "R1 k mismatch");
    run_op(2, 8, 2, 0, 2, 0, 0, "R1 zero colsb");
    run_op(1, 4, 1, 4, 1, 4, 0, "R2 after errors");

    summary();
  end
endmodule